// File: doc/BRIEF.md
# Auxiliary Channel Request/Reply Master

This block is the initiating end of a half-duplex, self-clocked side channel. A host hands it one request at a time: a 4-bit command, a 20-bit address, a byte count and, for writes, the bytes to send. The block then drives the line. It sends a preamble of zero bits, a stop marker and a 32-bit header. Write payload bytes follow the header. Every bit uses Manchester II coding at a parameterised bit rate, which is 1 Mbit/s by default. When the frame ends, the block releases the line and listens for the answer.

The answer must start with its own preamble and stop marker. The receiver locks onto the mid-bit transitions and rebuilds bytes from them. The first reply byte holds a result code. The bytes after it are read data. The host sees a one-cycle `done` pulse with a status code. For an acknowledged reply, the read bytes arrive before that pulse, one per strobe. A missing reply ends the request with a timeout status after a fixed number of bit periods.

Top module: `aux_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `req_ready`=1, `done`=0, `rd_valid`=0 and `aux_oe`=0. This holds even if reset arrives in the middle of a frame.
- R2: Each frame starts with 16 zero bits. A stop marker follows: the line is high for two bit periods, then low for two. A half-bit lasts CLK_HZ/(2·BIT_HZ) clock cycles.
- R3: Each bit cell has a transition at its centre. A 1 is sent high then low. A 0 is sent low then high.
- R4: After the stop marker, the header is sent MSB first. It is `req_cmd[3:0]`, then `req_addr[19:0]`, then `req_len-1` as 8 bits. When `req_cmd[0]`=0 (write), `req_len` payload bytes follow, each MSB first. Byte 0 is taken from `req_wdata[7:0]`. When `req_cmd[0]`=1 (read), no payload is sent.
- R5: After the last bit, the frame ends with another high-2/low-2 stop marker. Then `aux_oe` falls. `aux_oe` is high only while a frame is being driven.
- R6: A request with `req_len` of 0, or more than 16, is refused. `done` pulses on the clock edge that accepts it, with status 4 (bad length), and nothing is driven.
- R7: The timeout period is 300 bit periods and starts when the line is released. If no reply preamble and stop marker are recognised in that period, `done` pulses with status 3 (timeout).
- R8: The upper nibble of the first reply byte selects the status: 0 gives status 0 (ok), 1 gives 1 (nack), 2 gives 2 (defer), and any other value gives 1. `done` pulses once the reply line has stayed without a mid-bit transition for 1.5 bit periods.
- R9: Reply bytes after the first are put on `rd_data` with a one-cycle `rd_valid`, in order. This happens only when the code is 0. With any other code, `rd_valid` stays low.
- R10: The receiver locks only after 8 mid-bit transitions spaced one bit apart that follow the first one, so the reply preamble needs at least 9 zero bits. A reply with 8 preamble zeros is ignored and ends in a timeout.
- R11: `req_ready` is low from acceptance of a valid-length request until the `done` pulse. It is high again in the cycle `done` is high.
- R12: `done` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle; request taken when both high |
| req_cmd | input | 4 | Command; bit 0 set means read |
| req_addr | input | 20 | Target address |
| req_len | input | 8 | Byte count, 1 to MAX_BYTES |
| req_wdata | input | MAX_BYTES*8 | Write bytes, byte k at bits [8k+7:8k] |
| aux_out | output | 1 | Line level while driving |
| aux_oe | output | 1 | Line drive enable |
| aux_in | input | 1 | Line level as seen at the pin |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | 0 ok, 1 nack, 2 defer, 3 timeout, 4 bad length |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |

## Verification
The properties assume three things about the inputs. The request fields are looked at only on the accepting edge. The far end never drives the line while `aux_oe` is high. A reply uses the same bit period as the request, so the quarter-bit decoding windows apply. The bench model of the far end follows all three. It waits until it sees `aux_oe` low, adds a short gap, and then drives a reply at the nominal half-bit length. It raises `req_valid` for only one cycle per request, so no second request is presented while the block is busy.

// File: rtl/aux_pkg.sv
// Shared types and frame constants for the auxiliary channel master.
// Assumes a frame of preamble, stop marker, 32-bit header, payload, stop marker.
package aux_pkg;
    typedef enum logic [2:0] {
        ST_OK      = 3'd0,
        ST_NACK    = 3'd1,
        ST_DEFER   = 3'd2,
        ST_TIMEOUT = 3'd3,
        ST_BADLEN  = 3'd4
    } aux_status_e;

    localparam logic [3:0] RC_ACK   = 4'h0;
    localparam logic [3:0] RC_DEFER = 4'h2;

    localparam int SYNC_ZEROS = 16;  // preamble zero bits
    localparam int STOP_HALF  = 4;   // half-bits per stop level
    localparam int HDR_BITS   = 32;  // cmd + addr + len-1
    localparam int LOCK_EDGES = 8;   // receiver lock threshold

    // Map a reply result code onto the host status
    function automatic aux_status_e code_to_status(input logic [3:0] code);
        if (code == RC_ACK)        return ST_OK;
        else if (code == RC_DEFER) return ST_DEFER;
        else                       return ST_NACK;
    endfunction
endpackage

// File: rtl/aux_tick.sv
// Half-bit strobe from a fractional accumulator.
// Assumes CLK_HZ >= 2*BIT_HZ; the phase restarts whenever en is low.
module aux_tick #(
    parameter int CLK_HZ = 100_000_000,
    parameter int BIT_HZ = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int INC = 2 * BIT_HZ;
    localparam int AW  = $clog2(CLK_HZ + INC + 1);
    localparam logic [AW-1:0] INC_V = AW'(INC);
    localparam logic [AW-1:0] MOD_V = AW'(CLK_HZ);

    logic [AW-1:0] acc;

    assign tick = en && ((acc + INC_V) >= MOD_V);

    // Accumulate phase; wrap by the clock rate on each strobe
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  acc <= '0;
        else if (tick)      acc <= acc + INC_V - MOD_V;
        else                acc <= acc + INC_V;
    end
endmodule

// File: rtl/aux_tx.sv
// Manchester frame serialiser: preamble, stop, nbits of frame MSB first, stop.
// Assumes start is pulsed only while idle and tick comes from aux_tick.
module aux_tx
    import aux_pkg::*;
#(
    parameter int MAX_BYTES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [HDR_BITS+MAX_BYTES*8-1:0] frame,
    input  logic [$clog2(HDR_BITS+MAX_BYTES*8+1)-1:0] nbits,
    input  logic                   tick,
    output logic                   line,
    output logic                   oe,
    output logic                   fin
);
    localparam int FRAME_W = HDR_BITS + MAX_BYTES * 8;
    localparam int NB_W    = $clog2(FRAME_W + 1);
    localparam int PRE_H   = 2 * SYNC_ZEROS;
    localparam int DAT_H   = PRE_H + 2 * STOP_HALF;
    localparam int HW      = $clog2(DAT_H + 2 * FRAME_W + 2 * STOP_HALF + 1);

    logic              busy;
    logic [HW-1:0]     hidx;
    logic [FRAME_W-1:0] sr;
    logic [NB_W-1:0]   nb;
    logic [HW-1:0]     data_end, last_h;

    assign data_end = HW'(DAT_H) + HW'({nb, 1'b0});
    assign last_h   = data_end + HW'(2 * STOP_HALF - 1);
    assign oe       = busy;

    // Line level as a function of the half-bit position
    always_comb begin
        if (hidx < HW'(PRE_H))                       line = hidx[0];
        else if (hidx < HW'(PRE_H + STOP_HALF))      line = 1'b1;
        else if (hidx < HW'(DAT_H))                  line = 1'b0;
        else if (hidx < data_end)                    line = sr[FRAME_W-1] ^ hidx[0];
        else if (hidx < data_end + HW'(STOP_HALF))   line = 1'b1;
        else                                         line = 1'b0;
    end

    // Walk the half-bits, shifting the frame after each data bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            hidx <= '0;
            sr   <= '0;
            nb   <= '0;
            fin  <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                hidx <= '0;
                sr   <= frame;
                nb   <= nbits;
            end else if (busy && tick) begin
                if (hidx == last_h) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end else begin
                    hidx <= hidx + 1'b1;
                    if (hidx >= HW'(DAT_H) && hidx < data_end && hidx[0])
                        sr <= {sr[FRAME_W-2:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/aux_rx.sv
// Manchester reply decoder working on transition spacing in quarter-bit units.
// Assumes the reply bit rate equals BIT_HZ; en low returns it to preamble hunt.
module aux_rx
    import aux_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int BIT_HZ = 1_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       rx_in,
    output logic       byte_v,
    output logic [7:0] byte_o,
    output logic       started,
    output logic       rend
);
    localparam int Q  = CLK_HZ / (4 * BIT_HZ);
    localparam int CW = $clog2(12 * Q + 1);
    localparam int EW = $clog2(LOCK_EDGES + 1);
    localparam logic [CW-1:0] CMAX = CW'(12 * Q);

    typedef enum logic [1:0] {R_HUNT, R_STOP, R_DATA, R_HOLD} rx_state_e;

    rx_state_e     st;
    logic [2:0]    syn;
    logic [CW-1:0] cnt;
    logic [EW-1:0] ecnt;
    logic          first;
    logic [7:0]    sr;
    logic [2:0]    bc;
    logic          lvl, edg;
    logic [CW-1:0] mid_min, end_min;

    assign lvl     = syn[1];
    assign edg     = syn[1] ^ syn[2];
    assign started = (st == R_DATA) || (st == R_HOLD);
    assign mid_min = first ? CW'(9 * Q) : CW'(3 * Q);
    assign end_min = first ? CW'(12 * Q) : CW'(6 * Q);

    // Bring the line into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) syn <= '0;
        else        syn <= {syn[1:0], rx_in};
    end

    // Preamble lock, stop detection and bit recovery
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            st     <= R_HUNT;
            cnt    <= CMAX;
            ecnt   <= '0;
            first  <= 1'b0;
            sr     <= '0;
            bc     <= '0;
            byte_v <= 1'b0;
            byte_o <= '0;
            rend   <= 1'b0;
        end else begin
            byte_v <= 1'b0;
            rend   <= 1'b0;
            if (cnt != CMAX) cnt <= cnt + 1'b1;
            unique case (st)
                R_HUNT: begin
                    if (edg && cnt >= CW'(3 * Q)) begin
                        cnt <= '0;
                        if (cnt < CW'(6 * Q)) begin
                            if (ecnt != EW'(LOCK_EDGES)) ecnt <= ecnt + 1'b1;
                        end else begin
                            ecnt <= '0;
                        end
                    end else if (!edg && cnt >= CW'(6 * Q) && lvl &&
                                 ecnt == EW'(LOCK_EDGES)) begin
                        st <= R_STOP;
                    end
                end
                R_STOP: begin
                    if (edg && !lvl) begin
                        st    <= R_DATA;
                        cnt   <= '0;
                        first <= 1'b1;
                        bc    <= '0;
                    end
                end
                R_DATA: begin
                    if (cnt >= end_min) begin
                        st   <= R_HOLD;
                        rend <= 1'b1;
                    end else if (edg && cnt >= mid_min) begin
                        cnt   <= '0;
                        first <= 1'b0;
                        sr    <= {sr[6:0], ~lvl};
                        bc    <= bc + 1'b1;
                        if (bc == 3'd7) begin
                            byte_v <= 1'b1;
                            byte_o <= {sr[6:0], ~lvl};
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/aux_ctrl.sv
// Request/reply master for the auxiliary channel: takes one host request,
// drives the Manchester frame, waits for and decodes the reply.
// Assumes request fields are valid on the accepting edge only.
module aux_ctrl
    import aux_pkg::*;
#(
    parameter int CLK_HZ       = 100_000_000,
    parameter int BIT_HZ       = 1_000_000,
    parameter int MAX_BYTES    = 16,
    parameter int TIMEOUT_BITS = 300
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [3:0]             req_cmd,
    input  logic [19:0]            req_addr,
    input  logic [7:0]             req_len,
    input  logic [MAX_BYTES*8-1:0] req_wdata,
    output logic                   aux_out,
    output logic                   aux_oe,
    input  logic                   aux_in,
    output logic                   done,
    output logic [2:0]             status,
    output logic                   rd_valid,
    output logic [7:0]             rd_data
);
    localparam int FRAME_W = HDR_BITS + MAX_BYTES * 8;
    localparam int NB_W    = $clog2(FRAME_W + 1);
    localparam int TO_CYC  = TIMEOUT_BITS * (CLK_HZ / BIT_HZ);
    localparam int TW      = $clog2(TO_CYC + 1);

    typedef enum logic [1:0] {C_IDLE, C_SEND, C_WAIT, C_RECV} ctl_state_e;

    ctl_state_e         st;
    aux_status_e        status_q;
    logic [TW-1:0]      tcnt;
    logic               got_hdr;
    logic [3:0]         code;
    logic               len_ok, accept, tx_start, tick, tx_fin;
    logic [FRAME_W-1:0] frame;
    logic [NB_W-1:0]    nbits;
    logic               rx_en, rx_bv, rx_started, rx_end;
    logic [7:0]         rx_byte;

    assign req_ready = (st == C_IDLE);
    assign len_ok    = (req_len != 8'd0) && (req_len <= 8'(MAX_BYTES));
    assign accept    = req_valid && req_ready;
    assign tx_start  = accept && len_ok;
    assign rx_en     = (st == C_WAIT) || (st == C_RECV);
    assign status    = status_q;
    assign nbits     = NB_W'(HDR_BITS) + (req_cmd[0] ? '0 : NB_W'({req_len, 3'b000}));

    // Assemble header then payload with byte 0 leading
    always_comb begin
        frame = '0;
        frame[FRAME_W-1 -: HDR_BITS] = {req_cmd, req_addr, req_len - 8'd1};
        for (int k = 0; k < MAX_BYTES; k++)
            frame[(MAX_BYTES-1-k)*8 +: 8] = req_wdata[k*8 +: 8];
    end

    aux_tick #(.CLK_HZ(CLK_HZ), .BIT_HZ(BIT_HZ)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(aux_oe), .tick(tick)
    );

    aux_tx #(.MAX_BYTES(MAX_BYTES)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .frame(frame),
        .nbits(nbits), .tick(tick), .line(aux_out), .oe(aux_oe), .fin(tx_fin)
    );

    aux_rx #(.CLK_HZ(CLK_HZ), .BIT_HZ(BIT_HZ)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .rx_in(aux_in),
        .byte_v(rx_bv), .byte_o(rx_byte), .started(rx_started), .rend(rx_end)
    );

    // Transaction sequencing, timeout and result reporting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= C_IDLE;
            status_q <= ST_OK;
            tcnt     <= '0;
            got_hdr  <= 1'b0;
            code     <= '0;
            done     <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            done     <= 1'b0;
            rd_valid <= 1'b0;
            unique case (st)
                C_IDLE: begin
                    if (accept) begin
                        if (len_ok) begin
                            st <= C_SEND;
                        end else begin
                            done     <= 1'b1;
                            status_q <= ST_BADLEN;
                        end
                    end
                end
                C_SEND: begin
                    if (tx_fin) begin
                        st   <= C_WAIT;
                        tcnt <= '0;
                    end
                end
                C_WAIT: begin
                    if (rx_started) begin
                        st      <= C_RECV;
                        got_hdr <= 1'b0;
                    end else if (tcnt == TW'(TO_CYC - 1)) begin
                        st       <= C_IDLE;
                        done     <= 1'b1;
                        status_q <= ST_TIMEOUT;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                C_RECV: begin
                    if (rx_bv) begin
                        if (!got_hdr) begin
                            got_hdr <= 1'b1;
                            code    <= rx_byte[7:4];
                        end else if (code == RC_ACK) begin
                            rd_valid <= 1'b1;
                            rd_data  <= rx_byte;
                        end
                    end
                    if (rx_end) begin
                        st       <= C_IDLE;
                        done     <= 1'b1;
                        status_q <= got_hdr ? code_to_status(code) : ST_TIMEOUT;
                    end
                end
                default: st <= C_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/aux_ctrl_checker.sv
// Port-level properties of aux_ctrl, attached by bind.
// Assumes the synchronous active-low reset of the checked block.
module aux_ctrl_checker #(
    parameter int MAX_BYTES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [7:0] req_len,
    input logic       aux_oe,
    input logic       done,
    input logic [2:0] status,
    input logic       rd_valid
);
    p_badlen_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_len == 8'd0 || req_len > 8'(MAX_BYTES)))
        |=> (done && status == 3'd4 && !aux_oe));

    p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_len != 8'd0 && req_len <= 8'(MAX_BYTES))
        |=> (!req_ready && aux_oe && !done));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    p_oe_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        aux_oe |-> (!req_ready && !done));

    p_rd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!req_ready && !aux_oe));
endmodule

bind aux_ctrl aux_ctrl_checker #(.MAX_BYTES(MAX_BYTES)) u_aux_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_len(req_len), .aux_oe(aux_oe), .done(done), .status(status),
    .rd_valid(rd_valid)
);

// File: tb/aux_ctrl_test.sv
module aux_ctrl_test;
    localparam int HALF   = 10;          // cycles per half-bit at 5 Mbit/s
    localparam int TO_CYC = 300 * 2 * HALF;

    typedef struct packed {
        logic [3:0]  cmd;
        logic [19:0] addr;
        logic [7:0]  len;
        logic [3:0]  code;
        logic [4:0]  ndata;
        logic [4:0]  nsync;
        logic        hdr;
        logic [2:0]  exp;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{4'h8, 20'h00600, 8'd1,  4'h0, 5'd0, 5'd16, 1'b1, 3'd0},
        '{4'h9, 20'h00101, 8'd4,  4'h0, 5'd4, 5'd16, 1'b1, 3'd0},
        '{4'h8, 20'hABCDE, 8'd16, 4'h1, 5'd0, 5'd16, 1'b1, 3'd1},
        '{4'h9, 20'hFFFFF, 8'd2,  4'h2, 5'd2, 5'd16, 1'b1, 3'd2},
        '{4'h9, 20'h00200, 8'd3,  4'h0, 5'd0, 5'd0,  1'b0, 3'd3},
        '{4'h9, 20'h00300, 8'd1,  4'h0, 5'd0, 5'd8,  1'b0, 3'd3},
        '{4'h1, 20'h00050, 8'd2,  4'h5, 5'd2, 5'd16, 1'b1, 3'd1},
        '{4'hB, 20'h12345, 8'd1,  4'h0, 5'd1, 5'd9,  1'b1, 3'd0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [3:0]   req_cmd = '0;
    logic [19:0]  req_addr = '0;
    logic [7:0]   req_len = '0;
    logic [127:0] req_wdata = '0;
    logic         aux_out, aux_oe, aux_line, done, rd_valid;
    logic [2:0]   status;
    logic [7:0]   rd_data;
    logic         sink_lvl = 1'b0;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int done_n = 0;
    int done_cyc = 0;
    int rd_n = 0;
    logic [2:0] last_status = '0;
    logic [7:0] rd_buf [0:63];
    logic       lv [0:511];

    assign aux_line = aux_oe ? aux_out : sink_lvl;

    aux_ctrl #(.CLK_HZ(100_000_000), .BIT_HZ(5_000_000), .MAX_BYTES(16),
               .TIMEOUT_BITS(300)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len),
        .req_wdata(req_wdata), .aux_out(aux_out), .aux_oe(aux_oe),
        .aux_in(aux_line), .done(done), .status(status),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rd_valid && rd_n < 64) begin
            rd_buf[rd_n] = rd_data;
            rd_n = rd_n + 1;
        end
        if (done) begin
            done_n = done_n + 1;
            done_cyc = cyc;
            last_status = status;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_half(input logic v);
        sink_lvl = v;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int j = 7; j >= 0; j--) begin
            send_half(b[j]);
            send_half(~b[j]);
        end
    endtask

    task automatic send_stop();
        for (int j = 0; j < 4; j++) send_half(1'b1);
        for (int j = 0; j < 4; j++) send_half(1'b0);
    endtask

    function automatic logic [7:0] wbyte(input int i, input int k);
        return 8'(8'hA0 + i * 16 + k * 3);
    endfunction

    function automatic logic [7:0] rbyte(input int i, input int k);
        return 8'(8'h5A ^ (i * 8 + k));
    endfunction

    task automatic run_vec(input int i);
        vec_t v;
        int nbits, total, d0, r0, oe_cyc, exp_rd;
        bit oe_ok, pre_ok, man_ok, hdr_ok, stop_ok;
        logic [31:0] hdr;
        v = VECS[i];
        @(negedge clk);
        req_cmd  = v.cmd;
        req_addr = v.addr;
        req_len  = v.len;
        for (int k = 0; k < 16; k++) req_wdata[k*8 +: 8] = wbyte(i, k);
        req_valid = 1'b1;
        d0 = done_n;
        r0 = rd_n;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R11 ready low after accept", req_ready, 0);
        nbits = 32 + (v.cmd[0] ? 0 : 8 * int'(v.len));
        total = 48 + 2 * nbits;
        oe_ok = 1'b1;
        repeat (5) @(negedge clk);
        for (int h = 0; h < total; h++) begin
            lv[h] = aux_out;
            oe_ok &= aux_oe & ~req_ready;
            repeat (HALF) @(negedge clk);
        end
        chk(oe_ok, "R5 drive enabled through frame", oe_ok, 1);
        chk(aux_oe == 1'b0, "R5 line released after frame", aux_oe, 0);
        oe_cyc = cyc;
        pre_ok = 1'b1;
        for (int h = 0; h < 32; h++) pre_ok &= (lv[h] == h[0]);
        for (int h = 32; h < 36; h++) pre_ok &= lv[h];
        for (int h = 36; h < 40; h++) pre_ok &= ~lv[h];
        chk(pre_ok, "R2 preamble and stop marker", pre_ok, 1);
        man_ok = 1'b1;
        hdr_ok = 1'b1;
        hdr = {v.cmd, v.addr, v.len - 8'd1};
        for (int b = 0; b < nbits; b++) begin
            logic eb;
            man_ok &= (lv[40 + 2*b] != lv[41 + 2*b]);
            if (b < 32) eb = hdr[31 - b];
            else begin
                logic [7:0] wb;
                wb = wbyte(i, (b - 32) / 8);
                eb = wb[7 - ((b - 32) % 8)];
            end
            hdr_ok &= (lv[40 + 2*b] == eb);
        end
        chk(man_ok, "R3 mid-bit transition in every cell", man_ok, 1);
        chk(hdr_ok, "R4 header and payload bits", hdr_ok, 1);
        stop_ok = 1'b1;
        for (int h = 0; h < 4; h++) stop_ok &= lv[40 + 2*nbits + h];
        for (int h = 4; h < 8; h++) stop_ok &= ~lv[40 + 2*nbits + h];
        chk(stop_ok, "R5 closing stop marker", stop_ok, 1);
        if (v.nsync != 0) begin
            repeat (15) @(negedge clk);
            for (int z = 0; z < int'(v.nsync); z++) begin
                send_half(1'b0);
                send_half(1'b1);
            end
            send_stop();
            if (v.hdr) begin
                send_byte({v.code, 4'h0});
                for (int k = 0; k < int'(v.ndata); k++) send_byte(rbyte(i, k));
                send_stop();
            end
            sink_lvl = 1'b0;
        end
        while (done_n == d0) @(posedge clk);
        @(negedge clk);
        chk(last_status == v.exp, (v.nsync == 0 || !v.hdr) ? "R7 R10 timeout status" : "R8 reply status",
            last_status, v.exp);
        chk(done == 1'b0 && done_n == d0 + 1, "R12 single done pulse", done_n - d0, 1);
        chk(req_ready == 1'b1, "R11 ready after done", req_ready, 1);
        if (v.exp == 3'd3) begin
            chk((done_cyc - oe_cyc) >= TO_CYC - 10 && (done_cyc - oe_cyc) <= TO_CYC + 10,
                "R7 timeout period", done_cyc - oe_cyc, TO_CYC);
        end
        exp_rd = (v.hdr && v.code == 4'h0) ? int'(v.ndata) : 0;
        chk(rd_n - r0 == exp_rd, "R9 read byte count", rd_n - r0, exp_rd);
        for (int k = 0; k < exp_rd && (r0 + k) < 64; k++)
            chk(rd_buf[r0 + k] == rbyte(i, k), "R9 read byte value", rd_buf[r0 + k], rbyte(i, k));
    endtask

    task automatic bad_len(input logic [7:0] len);
        int d0;
        @(negedge clk);
        req_cmd = 4'h9;
        req_len = len;
        req_valid = 1'b1;
        d0 = done_n;
        @(negedge clk);
        req_valid = 1'b0;
        chk(done == 1'b1 && status == 3'd4, "R6 bad length status", status, 4);
        chk(aux_oe == 1'b0 && req_ready == 1'b1, "R6 nothing driven", aux_oe, 0);
        @(negedge clk);
        chk(done == 1'b0 && done_n == d0 + 1, "R12 bad length single pulse", done_n - d0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready && !done && !rd_valid && !aux_oe, "R1 reset state",
            {req_ready, done, rd_valid, aux_oe}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !done && !rd_valid && !aux_oe, "R1 idle after reset",
            {req_ready, done, rd_valid, aux_oe}, 4'b1000);
        for (int i = 0; i < 8; i++) run_vec(i);
        bad_len(8'd0);
        bad_len(8'd17);
        // reset in the middle of a frame
        @(negedge clk);
        req_cmd = 4'h8; req_len = 8'd4; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (100) @(negedge clk);
        chk(aux_oe == 1'b1, "R5 driving mid frame", aux_oe, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(req_ready && !done && !rd_valid && !aux_oe, "R1 reset mid frame",
            {req_ready, done, rd_valid, aux_oe}, 4'b1000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule